// File: doc/BRIEF.md
# Conditional delayed call sequencer

This block drives the fetch address of a small in-order control processor with eight stages (F1, F2, D1, D2, R1, R2, E, W). It decodes three transfer instructions: conditional delayed call, conditional delayed return and conditional delayed jump. For each one it tests a 4-bit condition against five status flags. A taken transfer redirects fetch. Three delay-slot instructions always run after a transfer, whether the condition holds or not.

Instruction memory is synchronous: the word for the address shown on `fetch_addr_o` arrives on `instr_i` one cycle later, while that instruction sits in F2. The condition is tested when the transfer reaches D2, using the flags present on `flags_i` in that cycle. The transfer then leaves an empty slot in R1 and carries that gap on to W. A taken call stores a return address in an internal return register. A taken return reloads fetch from that register. The block never drives the flags. It reports an illegal spacing of transfers on `hazard_o`.

Top module: `dcall_seq`

## Requirements
- R1: While reset is held, and in the first cycle after release, `fetch_addr_o` is 0 and `redirect_o`, `hazard_o` and `wb_vld_o` are low. Reset also clears the return register to 0.
- R2: When no transfer is taken, `fetch_addr_o` rises by 2 every cycle. Each instruction is 32 bits, or two 16-bit words.
- R3: A transfer word has bits [31:22] = 0111100110. Bits [21:20] select the kind: 01 = call, 10 = return, 00 = jump. Bits [19:16] hold the condition and bits [15:0] hold the signed offset. Any other word is an ordinary instruction.
- R4: The flags are `flags_i[0]`=ZF, [1]=NF, [2]=TF, [3]=LUF, [4]=LVF. The condition codes are: 0000 ZF==0; 0001 ZF==1; 0010 ZF==0 and NF==0; 0011 NF==0; 0100 NF==1; 0101 ZF==1 or NF==1; 1010 TF==1; 1011 TF==0; 1100 LUF==1; 1101 LVF==1; 1110 and 1111 always true.
- R5: Condition codes 0110, 0111, 1000 and 1001 are always false.
- R6: A taken call or jump at address A fetches A + 2 + offset, with the offset sign-extended and the sum taken modulo 2^16. An offset of 0xFFFE therefore fetches A again.
- R7: If a transfer is fetched in cycle t, the next three fetches are the following sequential addresses. When taken, the target is fetched in cycle t+4, and `redirect_o` is high in exactly that cycle.
- R8: A taken call sets the return register to A + 8. A taken return fetches the return register's value. A jump leaves the return register unchanged.
- R9: The condition uses the flags present in cycle t+3, when the transfer is in D2. Flag values in other cycles have no effect.
- R10: `wb_vld_o` is high from the seventh cycle after reset release, except in cycle t+7 for every transfer fetched in cycle t. The gap appears whether or not the transfer is taken.
- R11: If a transfer is fetched 1 to 3 instructions after another transfer, `hazard_o` pulses for one cycle, two cycles after the later fetch. A spacing of 4 or more gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word for the address fetched one cycle earlier |
| flags_i | input | 5 | Status flags: ZF, NF, TF, LUF, LVF from bit 0 upward |
| fetch_addr_o | output | 16 | Fetch address (F1) |
| redirect_o | output | 1 | High in the cycle a redirected target is fetched |
| hazard_o | output | 1 | Transfers placed too close together |
| wb_vld_o | output | 1 | The W stage holds a valid instruction |

## Verification
A wrong program counter or a wrong return register shows on `fetch_addr_o`. A PC error appears in the very next cycle. A return-register error appears in the cycle four fetches after a return. A wrong stage-valid bit, or a lost D2 decode, shows either as a missing or misplaced `redirect_o` pulse three cycles after the transfer leaves F1, or as a misplaced gap on `wb_vld_o` seven cycles after the fetch. A corrupt spacing history shows as a missing or extra `hazard_o` pulse two cycles after the later transfer is fetched. The bench therefore compares the fetch address, the redirect strobe and the W valid bit on every cycle against a model built from the requirements.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int OPC_W = 10;
    localparam logic [OPC_W-1:0] XFER_OPC = 10'b0111100110;

    typedef enum logic [1:0] {
        XK_JUMP = 2'b00,
        XK_CALL = 2'b01,
        XK_RET  = 2'b10,
        XK_NONE = 2'b11
    } xfer_kind_e;

    // zf is bit 0, lvf is bit 4
    typedef struct packed {
        logic lvf;
        logic luf;
        logic tf;
        logic nf;
        logic zf;
    } flags_t;

    typedef enum logic [3:0] {
        CC_NZ   = 4'b0000,
        CC_Z    = 4'b0001,
        CC_POS  = 4'b0010,
        CC_NNEG = 4'b0011,
        CC_NEG  = 4'b0100,
        CC_NPOS = 4'b0101,
        CC_TST  = 4'b1010,
        CC_NTST = 4'b1011,
        CC_UFL  = 4'b1100,
        CC_OFL  = 4'b1101,
        CC_ALW  = 4'b1110,
        CC_ALW2 = 4'b1111
    } cc_e;

endpackage

// File: rtl/dcs_decode.sv
module dcs_decode
    import dcs_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 16,
    parameter int CC_W    = 4
) (
    input  logic [INSTR_W-1:0] word_i,
    output xfer_kind_e         kind_o,
    output logic [CC_W-1:0]    cond_o,
    output logic [OFF_W-1:0]   off_o
);
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int KIND_LSB = OPC_LSB - 2;

    always_comb begin
        cond_o = word_i[OFF_W +: CC_W];
        off_o  = word_i[OFF_W-1:0];
        kind_o = XK_NONE;
        if (word_i[INSTR_W-1:OPC_LSB] == XFER_OPC) begin
            case (word_i[KIND_LSB +: 2])
                2'b00:   kind_o = XK_JUMP;
                2'b01:   kind_o = XK_CALL;
                2'b10:   kind_o = XK_RET;
                default: kind_o = XK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dcs_cond.sv
module dcs_cond
    import dcs_pkg::*;
#(
    parameter int CC_W = 4
) (
    input  logic [CC_W-1:0] cond_i,
    input  flags_t          flags_i,
    output logic            take_o
);
    always_comb begin
        case (cond_i)
            CC_NZ:            take_o = !flags_i.zf;
            CC_Z:             take_o =  flags_i.zf;
            CC_POS:           take_o = !flags_i.zf && !flags_i.nf;
            CC_NNEG:          take_o = !flags_i.nf;
            CC_NEG:           take_o =  flags_i.nf;
            CC_NPOS:          take_o =  flags_i.zf || flags_i.nf;
            CC_TST:           take_o =  flags_i.tf;
            CC_NTST:          take_o = !flags_i.tf;
            CC_UFL:           take_o =  flags_i.luf;
            CC_OFL:           take_o =  flags_i.lvf;
            CC_ALW, CC_ALW2:  take_o = 1'b1;
            default:          take_o = 1'b0;
        endcase
    end

    // R5: codes 0110..1001 never pass
    always_comb begin
        a_r5_reserved_false: assert (!(cond_i >= 4'd6 && cond_i <= 4'd9) || !take_o);
    end
endmodule

// File: rtl/dcs_hazard.sv
module dcs_hazard #(
    parameter int WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic xfer_i,
    output logic hazard_o
);
    typedef struct packed {
        logic [WIN-1:0] hist;
        logic           hz;
    } hz_st_t;

    hz_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.hz = 1'b0;
        if (vld_i) begin
            st_d.hz = xfer_i && (|st_q.hist);
            if (WIN > 1) begin
                st_d.hist = {st_q.hist[WIN-2:0], xfer_i};
            end else begin
                st_d.hist = WIN'(xfer_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hazard_o = st_q.hz;

    // R11: a pulse always comes from a transfer seen in the previous cycle
    a_r11_hazard_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_o |-> $past(vld_i && xfer_i));
    // R11: a pulse lasts one cycle when no transfer follows it
    a_r11_hazard_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_o && !(vld_i && xfer_i)) |=> !hazard_o);
endmodule

// File: rtl/dcall_seq.sv
module dcall_seq
    import dcs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 16,
    parameter int CC_W    = 4,
    parameter int SLOTS   = 3,
    parameter int INC     = 2,
    parameter int N_POST  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [4:0]         flags_i,
    output logic [ADDR_W-1:0]  fetch_addr_o,
    output logic               redirect_o,
    output logic               hazard_o,
    output logic               wb_vld_o
);
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(INC);
    localparam logic [ADDR_W-1:0] RET_OF = ADDR_W'((SLOTS + 1) * INC);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pc;
        xfer_kind_e        kind;
        logic [CC_W-1:0]   cond;
        logic [OFF_W-1:0]  off;
    } stage_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] rpc;
        logic              f2_vld;
        logic [ADDR_W-1:0] f2_pc;
        stage_t            d1;
        stage_t            d2;
        logic [N_POST-1:0] post_vld;
        logic              redir;
    } seq_st_t;

    seq_st_t st_d, st_q;

    xfer_kind_e       f2_kind;
    logic [CC_W-1:0]  f2_cond;
    logic [OFF_W-1:0] f2_off;
    logic             d2_pass;
    logic             d2_xfer;
    logic             d2_take;
    logic [ADDR_W-1:0] tgt;

    dcs_decode #(.INSTR_W(INSTR_W), .OFF_W(OFF_W), .CC_W(CC_W)) u_dec (
        .word_i (instr_i),
        .kind_o (f2_kind),
        .cond_o (f2_cond),
        .off_o  (f2_off)
    );

    dcs_cond #(.CC_W(CC_W)) u_cond (
        .cond_i  (st_q.d2.cond),
        .flags_i (flags_t'(flags_i)),
        .take_o  (d2_pass)
    );

    dcs_hazard #(.WIN(SLOTS)) u_hz (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (st_q.f2_vld),
        .xfer_i   (f2_kind != XK_NONE),
        .hazard_o (hazard_o)
    );

    always_comb begin
        st_d = st_q;

        // fetch side: every fetch is kept, delay slots are never cancelled
        st_d.f2_vld = 1'b1;
        st_d.f2_pc  = st_q.pc;

        st_d.d1.vld  = st_q.f2_vld;
        st_d.d1.pc   = st_q.f2_pc;
        st_d.d1.kind = st_q.f2_vld ? f2_kind : XK_NONE;
        st_d.d1.cond = f2_cond;
        st_d.d1.off  = f2_off;

        st_d.d2 = st_q.d1;

        // condition resolved in D2; a transfer does not advance to R1
        d2_xfer = st_q.d2.vld && (st_q.d2.kind != XK_NONE);
        d2_take = d2_xfer && d2_pass;

        if (N_POST > 1) begin
            st_d.post_vld = {st_q.post_vld[N_POST-2:0], st_q.d2.vld && !d2_xfer};
        end else begin
            st_d.post_vld = N_POST'(st_q.d2.vld && !d2_xfer);
        end

        if (st_q.d2.kind == XK_RET) begin
            tgt = st_q.rpc;
        end else begin
            tgt = st_q.d2.pc + STEP + ADDR_W'(signed'(st_q.d2.off));
        end

        st_d.redir = d2_take;
        st_d.pc    = d2_take ? tgt : (st_q.pc + STEP);
        if (d2_take && st_q.d2.kind == XK_CALL) begin
            st_d.rpc = st_q.d2.pc + RET_OF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign redirect_o   = st_q.redir;
    assign wb_vld_o     = st_q.post_vld[N_POST-1];

    // R2: without a redirect the fetch address steps by one instruction
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !redirect_o) |-> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + STEP));
    // R7: a redirect only follows a transfer sitting in D2
    a_r7_redirect_src: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> $past(st_q.d2.vld && st_q.d2.kind != XK_NONE));
    // R8: the return register only moves to the call address plus four instructions
    a_r8_rpc_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.rpc) |-> st_q.rpc == ADDR_W'($past(st_q.d2.pc) + RET_OF));
    // R10: a transfer in D2 leaves R1 empty
    a_r10_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.d2.vld && st_q.d2.kind != XK_NONE) |-> !st_q.post_vld[0]);
endmodule

// File: tb/dcall_seq_tb.sv
module dcall_seq_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_q = '0;
    logic [4:0]  flags = '0;
    logic [15:0] fetch_addr;
    logic        redirect, hazard, wb_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dcall_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_i      (instr_q),
        .flags_i      (flags),
        .fetch_addr_o (fetch_addr),
        .redirect_o   (redirect),
        .hazard_o     (hazard),
        .wb_vld_o     (wb_vld)
    );

    // program: two special slots, everything else is an ordinary word
    // kind: 0 none, 1 call, 2 return, 3 jump
    int          sk [2];
    logic [15:0] sa [2];
    logic [3:0]  sc [2];
    logic [15:0] so [2];
    bit          st [2];

    function automatic logic [31:0] enc(int k, logic [3:0] c, logic [15:0] o);
        logic [1:0] kb;
        kb = (k == 1) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00;
        return {10'b0111100110, kb, c, o};
    endfunction

    function automatic logic [31:0] imem(logic [15:0] a);
        for (int i = 0; i < 2; i++)
            if (sk[i] != 0 && sa[i] == a) return enc(sk[i], sc[i], so[i]);
        return 32'h0000_0000;
    endfunction

    always @(posedge clk) instr_q <= imem(fetch_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 2; i++) begin
            sk[i] = 0; sa[i] = '0; sc[i] = '0; so[i] = '0; st[i] = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        flags = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fetch_addr == 16'h0, "R1 addr", fetch_addr, 0);
        chk({redirect, hazard, wb_vld} == 3'b000, "R1 outs", {redirect, hazard, wb_vld}, 0);
        rst_n = 1'b1;
    endtask

    // walks nsteps cycles comparing fetch address, redirect and W valid
    task automatic run(input int nsteps, input logic [4:0] fb, input logic [4:0] fd,
                       input int d2s, input int exp_hz, input string tag);
        logic [15:0] exp_a, tgt, rpc_m;
        logic [63:0] gap;
        bit          exp_r;
        int          pend, hz;
        exp_a = '0; rpc_m = '0; tgt = '0; gap = '0; exp_r = 1'b0; pend = 0; hz = 0;
        for (int k = 0; k < nsteps; k++) begin
            chk(fetch_addr == exp_a, {tag, " R2/R6/R7/R8 addr"}, fetch_addr, exp_a);
            chk(redirect == exp_r, {tag, " R7 redirect"}, redirect, exp_r);
            chk(wb_vld == (k >= 7 && !gap[k]), {tag, " R10 wb"}, wb_vld, (k >= 7 && !gap[k]));
            if (hazard) hz++;
            flags = (k == d2s) ? fd : fb;
            for (int i = 0; i < 2; i++) begin
                if (sk[i] != 0 && sa[i] == exp_a) begin
                    if (k + 7 < 64) gap[k+7] = 1'b1;
                    if (st[i]) begin
                        pend = 4;
                        tgt = (sk[i] == 2) ? rpc_m : exp_a + 16'd2 + so[i];
                        if (sk[i] == 1) rpc_m = exp_a + 16'd8;
                    end
                end
            end
            exp_r = (pend == 1);
            exp_a = (pend == 1) ? tgt : exp_a + 16'd2;
            if (pend > 0) pend--;
            @(negedge clk);
        end
        chk(hz == exp_hz, {tag, " R11 hazard count"}, hz, exp_hz);
    endtask

    // {cond, flags(LVF,LUF,TF,NF,ZF), taken}: R4/R5 table
    localparam logic [9:0] VEC [20] = '{
        {4'b0000, 5'b00000, 1'b1}, {4'b0000, 5'b00001, 1'b0},
        {4'b0001, 5'b00001, 1'b1}, {4'b0001, 5'b00000, 1'b0},
        {4'b0010, 5'b00000, 1'b1}, {4'b0010, 5'b00010, 1'b0},
        {4'b0011, 5'b00001, 1'b1}, {4'b0100, 5'b00010, 1'b1},
        {4'b0100, 5'b00000, 1'b0}, {4'b0101, 5'b00001, 1'b1},
        {4'b0101, 5'b00000, 1'b0}, {4'b0110, 5'b11111, 1'b0},
        {4'b1001, 5'b11111, 1'b0}, {4'b1010, 5'b00100, 1'b1},
        {4'b1011, 5'b00100, 1'b0}, {4'b1100, 5'b01000, 1'b1},
        {4'b1101, 5'b10000, 1'b1}, {4'b1101, 5'b01000, 1'b0},
        {4'b1110, 5'b00000, 1'b1}, {4'b1111, 5'b11111, 1'b1}
    };

    initial begin
        // table: call at 0x10, offset 0x20 -> 0x32 (R3, R4, R5, R6, R7)
        foreach (VEC[v]) begin
            clr_prog();
            sk[0] = 1; sa[0] = 16'h0010; sc[0] = VEC[v][9:6]; so[0] = 16'h0020; st[0] = VEC[v][0];
            do_reset();
            run(24, VEC[v][5:1], VEC[v][5:1], -1, 0, $sformatf("R4 vec%0d", v));
        end

        // R6: offset 0xFFFE loops back onto the call
        clr_prog();
        sk[0] = 1; sa[0] = 16'h0010; sc[0] = 4'b1110; so[0] = 16'hFFFE; st[0] = 1'b1;
        do_reset();
        run(32, '0, '0, -1, 0, "R6 self-loop");

        // R8: call to 0x100, return at 0x106 comes back to 0x18
        clr_prog();
        sk[0] = 1; sa[0] = 16'h0010; sc[0] = 4'b1110; so[0] = 16'h00EE; st[0] = 1'b1;
        sk[1] = 2; sa[1] = 16'h0106; sc[1] = 4'b1111; st[1] = 1'b1;
        do_reset();
        run(30, '0, '0, -1, 0, "R8 call-return");

        // R8: return not taken (ZF==1 required, ZF clear)
        clr_prog();
        sk[0] = 1; sa[0] = 16'h0010; sc[0] = 4'b1110; so[0] = 16'h00EE; st[0] = 1'b1;
        sk[1] = 2; sa[1] = 16'h0106; sc[1] = 4'b0001; st[1] = 1'b0;
        do_reset();
        run(30, '0, '0, -1, 0, "R8 return not taken");

        // R8: jump to 0x40 leaves the return register at 0, return goes to 0
        clr_prog();
        sk[0] = 3; sa[0] = 16'h0010; sc[0] = 4'b1110; so[0] = 16'h002E; st[0] = 1'b1;
        sk[1] = 2; sa[1] = 16'h0040; sc[1] = 4'b1110; st[1] = 1'b1;
        do_reset();
        run(30, '0, '0, -1, 0, "R8 jump keeps rpc");

        // R9: ZF set only in the D2 cycle (step 11) -> EQ call taken
        clr_prog();
        sk[0] = 1; sa[0] = 16'h0010; sc[0] = 4'b0001; so[0] = 16'h0020; st[0] = 1'b1;
        do_reset();
        run(24, 5'b00000, 5'b00001, 11, 0, "R9 flag only in D2");

        // R9: ZF set in every cycle except D2 -> not taken
        clr_prog();
        sk[0] = 1; sa[0] = 16'h0010; sc[0] = 4'b0001; so[0] = 16'h0020; st[0] = 1'b0;
        do_reset();
        run(24, 5'b00001, 5'b00000, 11, 0, "R9 flag absent in D2");

        // R11: jump at 0x10, call at 0x16 (3 apart), both reserved-false
        clr_prog();
        sk[0] = 3; sa[0] = 16'h0010; sc[0] = 4'b0111;
        sk[1] = 1; sa[1] = 16'h0016; sc[1] = 4'b1000;
        do_reset();
        run(24, 5'b11111, 5'b11111, -1, 1, "R11 spacing 3");

        // R11: return at 0x10, call at 0x18 (4 apart) is legal
        clr_prog();
        sk[0] = 2; sa[0] = 16'h0010; sc[0] = 4'b0110;
        sk[1] = 1; sa[1] = 16'h0018; sc[1] = 4'b1001;
        do_reset();
        run(24, 5'b11111, 5'b11111, -1, 0, "R11 spacing 4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule